// File: doc/BRIEF.md
# Firmware-hub memory-cycle target

This block is the target end of a 4-bit multiplexed firmware-hub bus. On every clock it samples the nibble bus together with an active-low frame strobe. When it sees a start code while the frame strobe is low, it follows the rest of the frame. That frame carries a one-clock ID select, a 28-bit address sent as seven nibbles, and a memory size nibble.

On a single-byte read it waits through the host's turnaround and issues a read strobe on a byte-wide internal memory port. It drives short-wait sync codes until the memory answers, then ready, then the two data nibbles, then its own turnaround. On a write it first collects the two data nibbles and issues a write strobe. After the turnaround it answers with sync and then releases the bus.

Frames with an unknown start code, a foreign ID or a non-zero size are dropped without driving the bus. A low frame strobe in the middle of a frame abandons that frame.

Top module: `nibble_bus_target`

## Requirements
- R1: With `frame_n` low, bus nibble 1101b opens a read frame and 1110b opens a write frame. Any other nibble seen with `frame_n` low leaves the block idle: no drive and no memory strobe for the rest of that frame.
- R2: The nibble after the start code is the ID select. The frame proceeds only if it equals `id_strap`; otherwise the block stays silent and issues no memory strobe.
- R3: The next 7 nibbles form the address, most significant nibble (bits 27:24) first. Only bits 18:0 appear on `mem_addr`, so frames that differ only in bits 27:19 reach the same byte.
- R4: The nibble after the address is the size field. Any value other than 0000b returns the block to idle with no drive and no memory strobe.
- R5: On a read, the block leaves `bus_oe` low for the 2 turnaround clocks after the size field. It then drives 0101b (short wait) while the memory has not answered, and 0000b (ready) once the read byte is held. Next it drives the low data nibble and then the high data nibble. With a memory that raises `mem_ready` L clocks after the clock following the strobe, exactly L+1 short-wait nibbles appear.
- R6: On a write, the two nibbles after the size field are the data, low nibble first. Exactly one `mem_wr` pulse carries the assembled byte. Two undriven turnaround clocks follow, then L+1 short waits and a 0000b ready nibble.
- R7: After the last data nibble of a read, or after the ready nibble of a write, the block drives 1111b for one clock and then releases the bus.
- R8: `frame_n` low in any clock ends the current frame; `bus_oe` is low in the following clock, and the nibble in that clock is decoded as a new start code.
- R9: After reset and between frames `bus_oe` is low. `mem_rd` and `mem_wr` are one-clock pulses, never high together, and each accepted frame produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble sampled from the shared bus |
| bus_out | output | 4 | Nibble driven by this target |
| bus_oe | output | 1 | Output enable for `bus_out` |
| id_strap | input | 4 | ID this target answers to |
| mem_addr | output | AW | Byte address to the internal memory |
| mem_rd | output | 1 | One-clock read strobe |
| mem_wr | output | 1 | One-clock write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completion pulse |

## Verification
A wrong frame-state value shows at the ports within one or two clocks. Either `bus_oe` rises during a turnaround or header clock, or the count of short-wait nibbles differs from the latency the memory model was given. A misassembled address or data byte is seen at the memory port in the clock after the strobe. It is also seen on a later read-back of the same byte through a different address alias, a few frames later at most.

// File: rtl/nibble_bus_target.sv
module nibble_bus_target #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic [3:0]    bus_in,
  output logic [3:0]    bus_out,
  output logic          bus_oe,
  input  logic [3:0]    id_strap,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);
  localparam int ADDR_NIBS = 7;
  localparam logic [3:0] RD_CODE = 4'b1101;
  localparam logic [3:0] WR_CODE = 4'b1110;

  typedef enum logic [3:0] {
    IDLE, IDSEL, ADR, MSZ, WLO, WHI, TI1, TI2, SYN, RLO, RHI, TO1, TO2
  } state_t;

  state_t        state;
  logic          is_wr, pend, got;
  logic [2:0]    cnt;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;

  assign mem_addr  = addr;
  assign mem_wdata = wdata;
  assign bus_oe    = (state == SYN) || (state == RLO) || (state == RHI) || (state == TO1);

  always_comb begin
    case (state)
      SYN:     bus_out = got ? 4'b0000 : 4'b0101;
      RLO:     bus_out = rdata[3:0];
      RHI:     bus_out = rdata[7:4];
      TO1:     bus_out = 4'b1111;
      default: bus_out = 4'b0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      is_wr  <= 1'b0;
      pend   <= 1'b0;
      got    <= 1'b0;
      cnt    <= '0;
      addr   <= '0;
      wdata  <= '0;
      rdata  <= '0;
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      if (pend && mem_ready) begin
        pend <= 1'b0;
        got  <= 1'b1;
        if (!is_wr) rdata <= mem_rdata;
      end
      if (!frame_n) begin
        state <= (bus_in == RD_CODE || bus_in == WR_CODE) ? IDSEL : IDLE;
        is_wr <= (bus_in == WR_CODE);
      end else begin
        case (state)
          IDSEL: begin
            state <= (bus_in == id_strap) ? ADR : IDLE;
            cnt   <= '0;
          end
          ADR: begin
            addr <= {addr[AW-5:0], bus_in};
            cnt  <= cnt + 3'd1;
            if (cnt == 3'(ADDR_NIBS - 1)) state <= MSZ;
          end
          MSZ: begin
            if (bus_in != 4'b0000) state <= IDLE;
            else if (is_wr) state <= WLO;
            else begin
              state  <= TI1;
              mem_rd <= 1'b1;
              pend   <= 1'b1;
              got    <= 1'b0;
            end
          end
          WLO: begin
            wdata[3:0] <= bus_in;
            state      <= WHI;
          end
          WHI: begin
            wdata[7:4] <= bus_in;
            mem_wr     <= 1'b1;
            pend       <= 1'b1;
            got        <= 1'b0;
            state      <= TI1;
          end
          TI1:     state <= TI2;
          TI2:     state <= SYN;
          SYN:     if (got) state <= is_wr ? TO1 : RLO;
          RLO:     state <= RHI;
          RHI:     state <= TO1;
          TO1:     state <= TO2;
          default: state <= IDLE;
        endcase
      end
    end
  end
endmodule

module nibble_bus_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       bus_oe,
  input logic [3:0] bus_out,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [3:0] st
);
  localparam logic [3:0] S_SYN = 4'd8;
  localparam logic [3:0] S_RLO = 4'd9;
  localparam logic [3:0] S_TO1 = 4'd11;

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  p_rd_pulse_r9:   assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd);
  p_wr_pulse_r9:   assert property (@(posedge clk) disable iff (!rst_n) mem_wr |=> !mem_wr);
  p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n) !frame_n |=> !bus_oe);
  p_tar_release_r7: assert property (@(posedge clk) disable iff (!rst_n) (st == S_TO1) |=> !bus_oe);
  p_ready_then_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && st == S_SYN && bus_out == 4'b0000) |=> (st == S_RLO || st == S_TO1));
endmodule

bind nibble_bus_target nibble_bus_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .st(state)
);

// File: tb/test_nibble_bus_target.sv
`timescale 1ns/1ps
module test_nibble_bus_target;
  localparam int AW = 19;
  localparam logic [3:0] MY_ID = 4'h3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1;
  logic [3:0] host_nib = 4'hF;
  logic [3:0] bus_out;
  logic bus_oe;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  logic mem_ready = 1'b0;

  always #4 clk = ~clk;

  nibble_bus_target #(.AW(AW)) i_nibble_bus_target (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(host_nib),
    .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(MY_ID),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, lat = 0, lat_cnt = 0;
  bit busy = 0;
  logic [AW-1:0] last_addr = '0;
  logic [7:0] last_wdata = '0;
  logic [7:0] store [int];
  logic [7:0] refm [int];
  logic obs_oe;
  logic [3:0] obs_out;
  bit drove;

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[18:16], 5'b10101};
  endfunction

  function automatic logic [7:0] ref_byte(input logic [AW-1:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : pat(a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      busy = 0;
      mem_ready <= 1'b0;
    end else begin
      mem_ready <= 1'b0;
      if (busy) begin
        if (lat_cnt == 0) begin mem_ready <= 1'b1; busy = 0; end
        else lat_cnt = lat_cnt - 1;
      end
      if (mem_rd) begin
        busy = 1; lat_cnt = lat; rd_cnt++; last_addr = mem_addr;
        mem_rdata <= store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : pat(mem_addr);
      end
      if (mem_wr) begin
        busy = 1; lat_cnt = lat; wr_cnt++; last_addr = mem_addr; last_wdata = mem_wdata;
        store[int'(mem_addr)] = mem_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic cyc(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    frame_n = fr;
    host_nib = nib;
    obs_oe = bus_oe;
    obs_out = bus_out;
    drove = drove | obs_oe;
  endtask

  task automatic header(input logic [3:0] st, input logic [3:0] id, input logic [27:0] a, input logic [3:0] msz);
    cyc(1'b0, st);
    cyc(1'b1, id);
    for (int i = 0; i < 7; i++) cyc(1'b1, a[27-4*i -: 4]);
    cyc(1'b1, msz);
  endtask

  task automatic sync_wait(input string req, input int l);
    int waits = 0;
    cyc(1'b1, 4'hF);
    while (obs_oe && obs_out == 4'b0101 && waits < 40) begin
      waits++;
      cyc(1'b1, 4'hF);
    end
    check(obs_oe && obs_out == 4'b0000, req, "ready sync nibble", int'(obs_out), 0);
    check(waits == l + 1, req, "short-wait count", waits, l + 1);
  endtask

  task automatic do_read(input logic [27:0] a, input int l);
    int r0 = rd_cnt;
    logic [7:0] e = ref_byte(a[AW-1:0]);
    lat = l; drove = 0;
    header(4'b1101, MY_ID, a, 4'h0);
    cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
    check(!drove, "R5", "no drive in header/turnaround", int'(drove), 0);
    sync_wait("R5", l);
    cyc(1'b1, 4'hF);
    check(obs_oe && obs_out == e[3:0], "R5", "low data nibble", int'(obs_out), int'(e[3:0]));
    cyc(1'b1, 4'hF);
    check(obs_oe && obs_out == e[7:4], "R5", "high data nibble", int'(obs_out), int'(e[7:4]));
    cyc(1'b1, 4'hF);
    check(obs_oe && obs_out == 4'hF, "R7", "read end turnaround 1111", int'(obs_out), 15);
    cyc(1'b1, 4'hF);
    check(!obs_oe, "R7", "read bus released", int'(obs_oe), 0);
    check(rd_cnt == r0 + 1, "R9", "one read strobe", rd_cnt - r0, 1);
    check(last_addr == a[AW-1:0], "R3", "read address", int'(last_addr), int'(a[AW-1:0]));
  endtask

  task automatic do_write(input logic [27:0] a, input logic [7:0] d, input int l);
    int w0 = wr_cnt;
    lat = l; drove = 0;
    header(4'b1110, MY_ID, a, 4'h0);
    cyc(1'b1, d[3:0]); cyc(1'b1, d[7:4]);
    cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
    check(!drove, "R6", "no drive before sync", int'(drove), 0);
    sync_wait("R6", l);
    cyc(1'b1, 4'hF);
    check(obs_oe && obs_out == 4'hF, "R7", "write end turnaround 1111", int'(obs_out), 15);
    cyc(1'b1, 4'hF);
    check(!obs_oe, "R7", "write bus released", int'(obs_oe), 0);
    check(wr_cnt == w0 + 1, "R9", "one write strobe", wr_cnt - w0, 1);
    check(last_wdata == d, "R6", "write byte", int'(last_wdata), int'(d));
    check(last_addr == a[AW-1:0], "R3", "write address", int'(last_addr), int'(a[AW-1:0]));
    refm[int'(a[AW-1:0])] = d;
  endtask

  task automatic silent(input string req, input string what, input logic [3:0] st,
                        input logic [3:0] id, input logic [3:0] msz);
    int r0 = rd_cnt, w0 = wr_cnt;
    drove = 0;
    header(st, id, 28'h00ABCDE, msz);
    for (int i = 0; i < 14; i++) cyc(1'b1, 4'h0);
    check(!drove, req, {what, " bus stays undriven"}, int'(drove), 0);
    check(rd_cnt == r0 && wr_cnt == w0, req, {what, " no memory strobe"}, rd_cnt + wr_cnt - r0 - w0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    check(!bus_oe && !mem_rd && !mem_wr, "R9", "reset outputs quiet", int'({bus_oe, mem_rd, mem_wr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!bus_oe, "R9", "idle after reset", int'(bus_oe), 0);

    do_read(28'h0000010, 0);
    do_write(28'hFF7FFF2, 8'hA5, 2);
    do_read(28'h007FFF2, 1);
    do_read(28'hABFFFF2, 4);
    do_write(28'h1234567, 8'h3C, 0);
    do_read(28'h0034567, 3);

    silent("R1", "bad start 0000", 4'b0000, MY_ID, 4'h0);
    silent("R1", "bad start 1111", 4'b1111, MY_ID, 4'h0);
    silent("R2", "foreign ID", 4'b1101, MY_ID ^ 4'h1, 4'h0);
    silent("R2", "foreign ID write", 4'b1110, 4'hC, 4'h0);
    silent("R4", "size 0001", 4'b1101, MY_ID, 4'h1);
    silent("R4", "size 1000 write", 4'b1110, MY_ID, 4'h8);

    drove = 0;
    cyc(1'b0, 4'b1101); cyc(1'b1, MY_ID);
    cyc(1'b1, 4'h7); cyc(1'b1, 4'h7); cyc(1'b1, 4'h7);
    check(!drove, "R8", "no drive before abort", int'(drove), 0);
    do_write(28'h0055AA0, 8'h99, 1);
    cyc(1'b0, 4'b1110); cyc(1'b1, MY_ID); cyc(1'b1, 4'h1);
    do_read(28'hE055AA0, 0);

    for (int n = 0; n < 40; n++) begin
      logic [27:0] a;
      int l;
      a = 28'($urandom);
      if ($urandom_range(0, 1) == 1) a[AW-1:0] = 19'h7FFF0 + 19'($urandom_range(0, 7));
      l = $urandom_range(0, 5);
      if ($urandom_range(0, 1) == 1) do_write(a, 8'($urandom), l);
      else do_read(a, l);
      if ($urandom_range(0, 3) == 0) cyc(1'b1, 4'($urandom));
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule